// File: doc/BRIEF.md
# Message-Framed Reshaping Byte Pipe

This block is a byte FIFO between a producer and a consumer that need not agree on how payload is cut into pieces. A write request hands over a burst given as a byte count per element times an element count, and it may flag the last byte of that burst as the end of a message. A read request asks for its own element shape and count. It is held until the whole requested amount is buffered, or until a message end lies inside the requested span. In the second case it returns what was there up to and including the marked byte, together with the number of whole elements that span holds.

Both sides use valid/ready. A request finishes in the cycle its ready is high, and ready rises only once the whole operation can be done. A writer facing too little free space simply waits and loses nothing. Requests whose byte size is zero or above the build-time limit finish at once with an error flag and move no data. Because a read can only return short when the writer marked it, the bytes and counts a reader sees depend only on the stream and its markers, not on how writes and reads were sized or timed.

Top module: `msg_shape_pipe`

## Requirements
- R1: After reset the pipe is empty: a one-byte read request is held with rdReady low, and wrReady, wrError and rdError are low while no request is presented.
- R2: A legal write (byte size = wrElemBytes x wrElemCount, from 1 to MAX_BYTES) completes in one cycle with wrError low when enough space is free; byte i of the burst is wrData[8i+7:8i], and bytes leave the pipe in the order they were written.
- R3: The reader's shape is independent of the writer's: bytes written as two 3-byte... any shape are read back unchanged under a different bytes-per-element and count of the same total, with rdDoneCount equal to rdElemCount and rdEom low.
- R4: A read request with no message end in the buffered bytes stays pending (rdReady low) until rdElemBytes x rdElemCount bytes are buffered, then completes with the full count.
- R5: When a message-end byte lies before the last requested byte, the read completes early, returns the bytes up to and including the marked one in rdData bytes 0 upward, sets all higher rdData bytes to zero, sets rdEom high and reports rdDoneCount = floor(delivered bytes / rdElemBytes).
- R6: When the message-end byte is exactly the last requested byte, the read returns the full count with rdEom high.
- R7: A write whose size exceeds the free space is held with wrReady low and the buffer unchanged until a read frees enough room; it then completes and its bytes follow the earlier ones with none lost.
- R8: A write or read request whose byte size is zero or larger than MAX_BYTES completes at once with its error flag and ready high, stores or removes no byte, and leaves later traffic unchanged.
- R9: The message-end marker is consumed with its byte: bytes written after it form a new read, returned without rdEom unless marked themselves.
- R10: The number of buffered bytes never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request present |
| wrReady | output | 1 | Write request completes this cycle |
| wrError | output | 1 | Write request rejected for its size |
| wrData | input | MAX_BYTES*8 | Write payload, byte 0 in the low bits |
| wrElemBytes | input | BW | Bytes per element of the write |
| wrElemCount | input | BW | Element count of the write |
| wrEom | input | 1 | Last byte of this write ends a message |
| rdValid | input | 1 | Read request present |
| rdReady | output | 1 | Read request completes this cycle |
| rdError | output | 1 | Read request rejected for its size |
| rdElemBytes | input | BW | Bytes per element of the read |
| rdElemCount | input | BW | Element count of the read |
| rdData | output | MAX_BYTES*8 | Read payload, byte 0 in the low bits, unused bytes zero |
| rdDoneCount | output | BW | Whole elements delivered |
| rdEom | output | 1 | The read ended on a message-end byte |

## Verification
Reads are tried with an element shape that differs from the writer's on an unmarked stream, which separates true byte reshaping from passing whole writes through. Streams with a marker in the middle, at the very last requested byte, and followed by a fresh message tell apart early completion, a full completion that still reports the end, and a marker that wrongly survives its byte. A read issued against a partial fill, a write issued against a full buffer, and zero and oversize requests show that nothing completes before it may, that a stalled write loses no data, and that a rejected request leaves the stream untouched.

// File: rtl/msg_shape_pipe_pkg.sv
package msg_shape_pipe_pkg;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic             push;
    logic             pop;
    logic [CNT_W-1:0] pushCount;
    logic [CNT_W-1:0] popCount;
  } pipe_strobe_t;
endpackage

// File: rtl/msg_shape_pipe_store.sv
module msg_shape_pipe_store
  import msg_shape_pipe_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_BYTES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pipe_strobe_t           strb,
  input  logic [MAX_BYTES*8-1:0] wrData,
  input  logic                   wrEom,
  output logic [PW-1:0]          fillLevel,
  output logic [MAX_BYTES*8-1:0] peekData,
  output logic [MAX_BYTES-1:0]   peekEom
);
  logic [7:0]       memData [DEPTH];
  logic [DEPTH-1:0] memEom;
  logic [PW-1:0]    wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strb.push) begin
      for (int i = 0; i < MAX_BYTES; i++) begin
        if (CNT_W'(i) < strb.pushCount) begin
          memData[wrPtr[AW-1:0] + AW'(i)] <= wrData[8*i +: 8];
          memEom[wrPtr[AW-1:0] + AW'(i)]  <= wrEom && (CNT_W'(i) == strb.pushCount - 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PW'(strb.pushCount);
      if (strb.pop)  rdPtr <= rdPtr + PW'(strb.popCount);
    end
  end

  assign fillLevel = wrPtr - rdPtr;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gPeek
    assign peekData[8*g +: 8] = memData[rdPtr[AW-1:0] + AW'(g)];
    assign peekEom[g]         = memEom[rdPtr[AW-1:0] + AW'(g)];
  end
endmodule

// File: rtl/msg_shape_pipe_ctrl.sv
module msg_shape_pipe_ctrl
  import msg_shape_pipe_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_BYTES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int BW = $clog2(MAX_BYTES + 1),
  localparam int CW = (2 * BW > PW) ? 2 * BW : PW
) (
  input  logic                   wrValid,
  input  logic [BW-1:0]          wrElemBytes,
  input  logic [BW-1:0]          wrElemCount,
  output logic                   wrReady,
  output logic                   wrError,
  input  logic                   rdValid,
  input  logic [BW-1:0]          rdElemBytes,
  input  logic [BW-1:0]          rdElemCount,
  output logic                   rdReady,
  output logic                   rdError,
  output logic [MAX_BYTES*8-1:0] rdData,
  output logic [BW-1:0]          rdDoneCount,
  output logic                   rdEom,
  input  logic [PW-1:0]          fillLevel,
  input  logic [MAX_BYTES*8-1:0] peekData,
  input  logic [MAX_BYTES-1:0]   peekEom,
  output pipe_strobe_t           strb
);
  logic [CW-1:0] wrTotal, rdTotal, fillC, freeC, delivered;
  logic          wrLegal, rdLegal, eomHit, rdDone;
  logic [BW-1:0] wholeCount;

  assign wrTotal = CW'(wrElemBytes) * CW'(wrElemCount);
  assign rdTotal = CW'(rdElemBytes) * CW'(rdElemCount);
  assign fillC   = CW'(fillLevel);
  assign freeC   = CW'(DEPTH) - fillC;
  assign wrLegal = (wrTotal != '0) && (wrTotal <= CW'(MAX_BYTES));
  assign rdLegal = (rdTotal != '0) && (rdTotal <= CW'(MAX_BYTES));

  // first message-end byte inside the requested and buffered span
  always_comb begin
    eomHit    = 1'b0;
    delivered = rdTotal;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (!eomHit && CW'(i) < rdTotal && CW'(i) < fillC && peekEom[i]) begin
        eomHit    = 1'b1;
        delivered = CW'(i + 1);
      end
    end
  end

  // whole elements within the delivered bytes
  always_comb begin
    wholeCount = '0;
    for (int e = 1; e <= MAX_BYTES; e++) begin
      if (CW'(e) <= CW'(rdElemCount) && CW'(e) * CW'(rdElemBytes) <= delivered)
        wholeCount = BW'(e);
    end
  end

  assign rdDone = eomHit || (fillC >= rdTotal);

  assign wrError = wrValid && !wrLegal;
  assign wrReady = wrValid && (!wrLegal || freeC >= wrTotal);
  assign rdError = rdValid && !rdLegal;
  assign rdReady = rdValid && (!rdLegal || rdDone);

  always_comb begin
    strb.push      = wrValid && wrLegal && (freeC >= wrTotal);
    strb.pushCount = CNT_W'(wrTotal);
    strb.pop       = rdValid && rdLegal && rdDone;
    strb.popCount  = CNT_W'(delivered);
  end

  assign rdEom       = strb.pop && eomHit;
  assign rdDoneCount = strb.pop ? wholeCount : '0;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gOut
    assign rdData[8*g +: 8] = (CW'(g) < delivered) ? peekData[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/msg_shape_pipe.sv
module msg_shape_pipe
  import msg_shape_pipe_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_BYTES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int BW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  output logic                   wrReady,
  output logic                   wrError,
  input  logic [MAX_BYTES*8-1:0] wrData,
  input  logic [BW-1:0]          wrElemBytes,
  input  logic [BW-1:0]          wrElemCount,
  input  logic                   wrEom,
  input  logic                   rdValid,
  output logic                   rdReady,
  output logic                   rdError,
  input  logic [BW-1:0]          rdElemBytes,
  input  logic [BW-1:0]          rdElemCount,
  output logic [MAX_BYTES*8-1:0] rdData,
  output logic [BW-1:0]          rdDoneCount,
  output logic                   rdEom
);
  pipe_strobe_t          strb;
  logic [PW-1:0]         fillLevel;
  logic [MAX_BYTES*8-1:0] peekData;
  logic [MAX_BYTES-1:0]  peekEom;

  msg_shape_pipe_store #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .wrEom(wrEom),
    .fillLevel(fillLevel), .peekData(peekData), .peekEom(peekEom)
  );

  msg_shape_pipe_ctrl #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .wrValid(wrValid), .wrElemBytes(wrElemBytes), .wrElemCount(wrElemCount),
    .wrReady(wrReady), .wrError(wrError),
    .rdValid(rdValid), .rdElemBytes(rdElemBytes), .rdElemCount(rdElemCount),
    .rdReady(rdReady), .rdError(rdError), .rdData(rdData),
    .rdDoneCount(rdDoneCount), .rdEom(rdEom),
    .fillLevel(fillLevel), .peekData(peekData), .peekEom(peekEom), .strb(strb)
  );
endmodule

// File: rtl/msg_shape_pipe_chk.sv
module msg_shape_pipe_chk #(
  parameter int DEPTH     = 16,
  parameter int MAX_BYTES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int BW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrValid,
  input logic          wrReady,
  input logic          wrError,
  input logic          rdValid,
  input logic          rdReady,
  input logic          rdError,
  input logic          rdEom,
  input logic [BW-1:0] rdElemCount,
  input logic [BW-1:0] rdDoneCount,
  input logic [PW-1:0] fillLevel
);
  assert_wr_ready_needs_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> wrValid);

  assert_full_read_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReady && !rdError && !rdEom) |-> (rdDoneCount == rdElemCount));

  assert_early_read_short_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdReady && rdEom) |-> (rdDoneCount <= rdElemCount));

  assert_stall_keeps_buffer_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady && !rdReady) |=> (fillLevel == $past(fillLevel)));

  assert_wr_error_completes_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrError |-> wrReady);

  assert_rd_error_completes_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdError |-> (rdReady && !rdEom));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= PW'(DEPTH));
endmodule

bind msg_shape_pipe msg_shape_pipe_chk #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .wrError(wrError),
  .rdValid(rdValid), .rdReady(rdReady), .rdError(rdError), .rdEom(rdEom),
  .rdElemCount(rdElemCount), .rdDoneCount(rdDoneCount), .fillLevel(fillLevel)
);

// File: tb/msg_shape_pipe_tb.sv
module msg_shape_pipe_tb;
  localparam int DEPTH = 16;
  localparam int MB    = 8;
  localparam int BW    = $clog2(MB + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0, wrEom = 1'b0, rdValid = 1'b0;
  logic [MB*8-1:0] wrData = '0;
  logic [BW-1:0] wrElemBytes = '0, wrElemCount = '0, rdElemBytes = '0, rdElemCount = '0;
  logic wrReady, wrError, rdReady, rdError, rdEom;
  logic [MB*8-1:0] rdData;
  logic [BW-1:0] rdDoneCount;

  msg_shape_pipe #(.DEPTH(DEPTH), .MAX_BYTES(MB)) u_dut (.*);

  always #2 clk = ~clk;

  int nChecks = 0, nFail = 0;
  byte unsigned qByte[$];
  bit           qEom[$];
  byte unsigned seed = 8'h10;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doWrite(int bpe, int n, bit eom, string req);
    int total = bpe * n;
    int waitCnt = 0;
    @(negedge clk);
    wrElemBytes = BW'(bpe); wrElemCount = BW'(n); wrEom = eom;
    for (int i = 0; i < MB; i++) wrData[8*i +: 8] = seed + 8'(i);
    wrValid = 1'b1;
    #1;
    while (!wrReady && waitCnt < 1000) begin @(negedge clk); #1; waitCnt++; end
    chk(wrReady == 1'b1, req, "write completes", int'(wrReady), 1);
    chk(wrError == 1'b0, req, "write error flag", int'(wrError), 0);
    for (int i = 0; i < total; i++) begin
      qByte.push_back(seed + 8'(i));
      qEom.push_back(eom && (i == total - 1));
    end
    seed = seed + 8'(total);
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  task automatic doRead(int bpe, int n, string req);
    int total = bpe * n;
    int dlv, waitCnt = 0;
    bit hit = 0;
    @(negedge clk);
    rdElemBytes = BW'(bpe); rdElemCount = BW'(n); rdValid = 1'b1;
    #1;
    while (!rdReady && waitCnt < 1000) begin @(negedge clk); #1; waitCnt++; end
    chk(rdReady == 1'b1, req, "read completes", int'(rdReady), 1);
    dlv = total;
    for (int i = 0; i < total && i < qByte.size(); i++)
      if (!hit && qEom[i]) begin hit = 1; dlv = i + 1; end
    chk(rdEom == hit, req, "rdEom", int'(rdEom), int'(hit));
    chk(int'(rdDoneCount) == dlv / bpe, req, "rdDoneCount", int'(rdDoneCount), dlv / bpe);
    for (int i = 0; i < MB; i++) begin
      int e = (i < dlv && i < qByte.size()) ? int'(qByte[i]) : 0;
      chk(int'(rdData[8*i +: 8]) == e, req, $sformatf("rdData byte %0d", i), int'(rdData[8*i +: 8]), e);
    end
    for (int i = 0; i < dlv && qByte.size() > 0; i++) begin
      void'(qByte.pop_front()); void'(qEom.pop_front());
    end
    @(posedge clk); #1;
    rdValid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", "run timed out", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: empty after reset
    @(negedge clk); #1;
    chk(wrReady == 0 && wrError == 0 && rdError == 0, "R1", "idle flags", int'({wrReady, wrError, rdError}), 0);
    rdElemBytes = 1; rdElemCount = 1; rdValid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(rdReady == 1'b0, "R1", "read held on empty pipe", int'(rdReady), 0);
    @(negedge clk); rdValid = 1'b0;

    // R2 R3: reshape 2x3 into 3x2
    doWrite(2, 3, 0, "R2");
    doRead(3, 2, "R3");

    // R5: marker at third byte of an eight-byte read
    doWrite(1, 3, 1, "R2");
    doRead(2, 4, "R5");

    // R6: marker at exactly the last requested byte
    doWrite(4, 1, 1, "R2");
    doRead(2, 2, "R6");

    // R9: marker consumed with its byte
    doWrite(1, 2, 1, "R2");
    doWrite(1, 2, 0, "R2");
    doRead(1, 4, "R9");
    doRead(1, 2, "R9");

    // R4: read pending on a partial fill
    doWrite(1, 2, 0, "R2");
    fork
      doRead(1, 4, "R4");
      begin
        repeat (5) @(negedge clk);
        #1;
        chk(rdReady == 1'b0, "R4", "read held on partial fill", int'(rdReady), 0);
        doWrite(1, 2, 0, "R4");
      end
    join

    // R8: illegal sizes rejected, stream unaffected
    @(negedge clk);
    wrElemBytes = 0; wrElemCount = 3; wrValid = 1'b1; #1;
    chk(wrError && wrReady, "R8", "zero-size write rejected", int'({wrError, wrReady}), 3);
    @(negedge clk);
    wrElemBytes = 3; wrElemCount = 3; #1;
    chk(wrError && wrReady, "R8", "oversize write rejected", int'({wrError, wrReady}), 3);
    @(negedge clk); wrValid = 1'b0;
    doWrite(1, 1, 0, "R8");
    @(negedge clk);
    rdElemBytes = 3; rdElemCount = 3; rdValid = 1'b1; #1;
    chk(rdError && rdReady && !rdEom, "R8", "oversize read rejected", int'({rdError, rdReady, rdEom}), 6);
    @(negedge clk);
    rdElemBytes = 2; rdElemCount = 0; #1;
    chk(rdError && rdReady, "R8", "zero-size read rejected", int'({rdError, rdReady}), 3);
    @(negedge clk); rdValid = 1'b0;
    doRead(1, 1, "R8");

    // R7: back-pressure on a full pipe
    doWrite(8, 1, 0, "R7");
    doWrite(4, 2, 0, "R7");
    fork
      doWrite(1, 4, 0, "R7");
      begin
        repeat (4) @(negedge clk);
        #1;
        chk(wrReady == 1'b0, "R7", "write held on full pipe", int'(wrReady), 0);
        doRead(2, 4, "R7");
      end
    join
    doRead(4, 2, "R7");
    doRead(2, 2, "R7");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule